// File: doc/BRIEF.md
# Self-Referenced PWM Symbol Decoder

This block takes a pulse-width-modulated line and turns each carrier period back into a 2-bit symbol. It uses no recovered sampling clock. A fast local clock oversamples the line. Each detected rising edge starts an age counter, and that edge becomes the timing origin for the period.

At three fixed ages after the edge, the block records whether the line is still high. Each record tells whether the data-modulated falling edge has come yet. The three records form a thermometer code. The code's population count is the symbol.

One clock after the last reference age, the symbol is presented together with a one-cycle valid strobe. A serialiser, selected by a parameter, then shifts the symbol out MSB first. Each bit is held for half a carrier period.

With the default parameters:
- A phase slot is 4 clocks.
- The carrier period is 32 clocks.
- Symbol k is sent as a pulse of (k+1) slots.
- The reference ages fall midway between the nominal falling edges, at 6, 10 and 14 clocks after edge detection.
- A trim parameter moves all three reference ages together, for delay calibration.

Top module: `pwm_symbol_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `sym_o`, `sym_valid_o`, `sym_err_o` and `ser_o` are all 0. Reset also clears the measurement and the latched comparator results.
- R2: The line passes through a two-flop synchroniser. A low-to-high step of the synchronised level starts a measurement. The synchronised level is then recorded at ages SLOT_CLK*(i+1)+SLOT_CLK/2 clocks after that start, for i = 0, 1, 2 (6, 10 and 14 by default). Each record is 1 when the line is still high at that age.
- R3: The comparator results are ordered as a code c[2:0], with c[0] the earliest record. The codes 000, 001, 011 and 111 decode to symbols 0, 1, 2 and 3. As a result, a pulse that stays high for W clocks decodes to the number of reference ages that are smaller than W.
- R4: `sym_valid_o` is high for exactly one cycle per measurement, one clock after the last reference age. With the defaults it is first seen high 17 clocks after the line rises. `sym_o` updates only together with that strobe and holds its value otherwise.
- R5: A new rising edge that arrives before the last reference age has been sampled aborts the current measurement. The abort produces a one-cycle `sym_err_o` pulse and no valid strobe for the aborted period. A fresh measurement then starts from the new edge.
- R6: When the serialiser is enabled, `ser_o` carries the symbol MSB for HALF_CLK clocks (16 by default), starting one clock after the valid strobe. It then carries the LSB for HALF_CLK clocks, and is 0 when nothing is being shifted.
- R7: A line held steadily high or steadily low produces no further strobes: exactly one measurement per rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | PWM line, asynchronous to clk |
| sym_o | output | 2 | Last decoded symbol |
| sym_valid_o | output | 1 | One-cycle strobe marking a new symbol |
| sym_err_o | output | 1 | One-cycle pulse on an aborted measurement or a non-thermometer code |
| ser_o | output | 1 | Serial symbol bits, MSB first |

## Verification
The assertions watch several properties on every cycle:
- The age counter stays inside its measurement window.
- An abort restarts the count at age one and raises the error with no strobe.
- The last reference sample is always followed by a single-cycle strobe.
- The symbol never changes without that strobe.
- The serial output is 0 whenever the shifter is empty.

Only the bench's scenarios can show the end-to-end properties:
- The decoded value and the exact 17-clock latency for every pulse width from 1 to 30 clocks.
- The MSB-then-LSB serial timing across back-to-back periods.
- That a held line yields one symbol.
- That an abort followed by a fresh edge decodes the second pulse correctly.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;

    localparam int SYM_W = 2;
    localparam int NREF  = (1 << SYM_W) - 1;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NREF-1:0]  therm_t;

    typedef enum logic {
        MEAS_IDLE = 1'b0,
        MEAS_RUN  = 1'b1
    } meas_state_e;

    typedef struct packed {
        sym_t sym;
        logic bad;
    } decode_t;

    // Age in clocks of reference point idx, measured from edge detection.
    function automatic int ref_age(input int idx, input int slot_clk, input int trim);
        return slot_clk * (idx + 1) + slot_clk / 2 + trim;
    endfunction

    // Thermometer to binary: symbol is the population count; a code that is
    // not a clean run of ones from bit 0 is flagged.
    function automatic decode_t therm_decode(input therm_t code);
        decode_t d;
        int      ones;
        therm_t  ideal;
        ones = 0;
        for (int i = 0; i < NREF; i++) begin
            if (code[i]) ones++;
        end
        ideal = '0;
        for (int i = 0; i < NREF; i++) begin
            if (i < ones) ideal[i] = 1'b1;
        end
        d.sym = sym_t'(ones);
        d.bad = (code != ideal);
        return d;
    endfunction

endpackage

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic rise_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;

    // R2: a rise is reported only on a fresh step of the synchronised level
    a_r2_single_rise : assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pwm_ref_timer.sv
module pwm_ref_timer
    import pwm_dec_pkg::*;
#(
    parameter int SLOT_CLK = 4,
    parameter int REF_TRIM = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rise_i,
    output logic [NREF-1:0] ref_hit_o,
    output logic            abort_o
);

    localparam int LAST_AGE = ref_age(NREF - 1, SLOT_CLK, REF_TRIM);
    localparam int CNT_W    = $clog2(LAST_AGE + 1) + 1;

    meas_state_e      state_q;
    logic [CNT_W-1:0] age_q;
    logic             running;

    assign running = (state_q == MEAS_RUN);
    // An edge arriving while the last reference is still pending aborts.
    assign abort_o = rise_i & running;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MEAS_IDLE;
            age_q   <= '0;
        end else if (rise_i) begin
            state_q <= MEAS_RUN;
            age_q   <= CNT_W'(1);
        end else if (running) begin
            if (age_q == CNT_W'(LAST_AGE)) begin
                state_q <= MEAS_IDLE;
            end else begin
                age_q <= age_q + CNT_W'(1);
            end
        end
    end

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        localparam int AGE = ref_age(i, SLOT_CLK, REF_TRIM);
        assign ref_hit_o[i] = running & ~rise_i & (age_q == CNT_W'(AGE));
    end

    // R2: the age stays inside the measurement window while running
    a_r2_age_window : assert property (@(posedge clk) disable iff (rst)
        running |-> (age_q >= CNT_W'(1)) && (age_q <= CNT_W'(LAST_AGE)));

    // R5: an abort restarts the count from age one
    a_r5_abort_restart : assert property (@(posedge clk) disable iff (rst)
        abort_o |=> (state_q == MEAS_RUN) && (age_q == CNT_W'(1)));

    // R4: reference hits are mutually exclusive
    a_r4_hits_onehot : assert property (@(posedge clk) disable iff (rst)
        $onehot0(ref_hit_o));

endmodule

// File: rtl/pwm_therm_latch.sv
module pwm_therm_latch
    import pwm_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            level_i,
    input  logic            rise_i,
    input  logic [NREF-1:0] ref_hit_i,
    input  logic            abort_i,
    output sym_t            sym_o,
    output logic            valid_o,
    output logic            err_o
);

    therm_t  therm_q;
    therm_t  cur_code;
    decode_t dec;
    logic    last_hit;

    assign last_hit = ref_hit_i[NREF-1];

    // Code as it stands this cycle, including a sample taken right now.
    always_comb begin
        for (int i = 0; i < NREF; i++) begin
            cur_code[i] = ref_hit_i[i] ? level_i : therm_q[i];
        end
    end

    assign dec = therm_decode(cur_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            therm_q <= '0;
            sym_o   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            if (rise_i) begin
                therm_q <= '0;
            end else begin
                therm_q <= cur_code;
            end
            valid_o <= last_hit;
            err_o   <= abort_i | (last_hit & dec.bad);
            if (last_hit) begin
                sym_o <= dec.sym;
            end
        end
    end

    // R4: the strobe lasts a single cycle
    a_r4_valid_pulse : assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R4: the symbol only moves together with its strobe
    a_r4_sym_hold : assert property (@(posedge clk) disable iff (rst)
        (sym_o != $past(sym_o)) |-> valid_o);

endmodule

// File: rtl/pwm_serialiser.sv
module pwm_serialiser
    import pwm_dec_pkg::*;
#(
    parameter int HALF_CLK = 16,
    parameter bit ENABLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  sym_t sym_i,
    output logic ser_o
);

    if (ENABLE) begin : g_ser
        localparam int HC_W = (HALF_CLK > 1) ? $clog2(HALF_CLK) : 1;
        localparam int BL_W = $clog2(SYM_W + 1);

        sym_t            shreg_q;
        logic [HC_W-1:0] half_q;
        logic [BL_W-1:0] left_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shreg_q <= '0;
                half_q  <= '0;
                left_q  <= '0;
            end else if (load_i) begin
                shreg_q <= sym_i;
                half_q  <= '0;
                left_q  <= BL_W'(SYM_W);
            end else if (left_q != '0) begin
                if (half_q == HC_W'(HALF_CLK - 1)) begin
                    half_q  <= '0;
                    left_q  <= left_q - BL_W'(1);
                    shreg_q <= shreg_q << 1;
                end else begin
                    half_q <= half_q + HC_W'(1);
                end
            end
        end

        assign ser_o = (left_q != '0) ? shreg_q[SYM_W-1] : 1'b0;

        // R6: nothing is driven when the shifter is empty
        a_r6_idle_zero : assert property (@(posedge clk) disable iff (rst)
            (left_q == '0) |-> !ser_o);

        // R6: a load always starts with the MSB of the new symbol
        a_r6_msb_first : assert property (@(posedge clk) disable iff (rst)
            load_i |=> (ser_o == $past(sym_i[SYM_W-1])));
    end else begin : g_noser
        assign ser_o = 1'b0;
    end

endmodule

// File: rtl/pwm_symbol_decoder.sv
module pwm_symbol_decoder
    import pwm_dec_pkg::*;
#(
    parameter int SLOT_CLK = 4,
    parameter int REF_TRIM = 0,
    parameter int HALF_CLK = 16,
    parameter bit SER_EN   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             sym_valid_o,
    output logic             sym_err_o,
    output logic             ser_o
);

    logic            level;
    logic            rise;
    logic [NREF-1:0] ref_hit;
    logic            abort;
    sym_t            sym;

    pwm_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line_i),
        .level_o (level),
        .rise_o  (rise)
    );

    pwm_ref_timer #(
        .SLOT_CLK (SLOT_CLK),
        .REF_TRIM (REF_TRIM)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .ref_hit_o (ref_hit),
        .abort_o   (abort)
    );

    pwm_therm_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .level_i   (level),
        .rise_i    (rise),
        .ref_hit_i (ref_hit),
        .abort_i   (abort),
        .sym_o     (sym),
        .valid_o   (sym_valid_o),
        .err_o     (sym_err_o)
    );

    pwm_serialiser #(
        .HALF_CLK (HALF_CLK),
        .ENABLE   (SER_EN)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load_i (sym_valid_o),
        .sym_i  (sym),
        .ser_o  (ser_o)
    );

    assign sym_o = sym;

    // R4: the last reference sample is always followed by the strobe
    a_r4_valid_after_last : assert property (@(posedge clk) disable iff (rst)
        ref_hit[NREF-1] |=> sym_valid_o);

    // R5: an aborted period raises the error and gives no strobe
    a_r5_abort_err : assert property (@(posedge clk) disable iff (rst)
        abort |=> sym_err_o && !sym_valid_o);

endmodule

// File: tb/pwm_symbol_decoder_test.sv
`timescale 1ns/1ps
module pwm_symbol_decoder_test;

    localparam int SLOT   = 4;
    localparam int HALF   = 16;
    localparam int PERIOD = 32;
    localparam int LAT    = 2 + (SLOT * 3 + SLOT / 2) + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line = 1'b0;
    logic [1:0] sym;
    logic       vld;
    logic       err;
    logic       ser;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit have_prev = 0;
    int prev_sym  = 0;

    pwm_symbol_decoder uut (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .sym_o       (sym),
        .sym_valid_o (vld),
        .sym_err_o   (err),
        .ser_o       (ser)
    );

    always #5 clk = ~clk;

    function automatic int exp_sym(input int w);
        int s = 0;
        for (int i = 0; i < 3; i++) begin
            if (SLOT * (i + 1) + SLOT / 2 < w) s++;
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one pulse of w clocks at the start of a win-clock window.
    task automatic send(input int w, input int win);
        int first = -1;
        int vc = 0;
        int ec = 0;
        int s = 0;
        int e = exp_sym(w);
        line = 1'b1;
        for (int t = 1; t <= win; t++) begin
            @(negedge clk);
            if (t == w) line = 1'b0;
            if (vld) begin
                if (first < 0) first = t;
                vc++;
                s = int'(sym);
            end
            if (err) ec++;
            if (t == 8 && have_prev)
                chk(ser == prev_sym[0], "R6 lsb", int'(ser), prev_sym[0]);
            if (t == 25)
                chk(ser == e[1], "R6 msb", int'(ser), e[1]);
        end
        chk(first == LAT, "R4 latency", first, LAT);
        chk(vc == 1, "R4 single strobe", vc, 1);
        chk(s == e, "R3 symbol", s, e);
        chk(ec == 0, "R5 no error", ec, 0);
        prev_sym  = e;
        have_prev = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(vld == 0 && err == 0 && ser == 0 && sym == 0, "R1 in reset",
            int'({sym, vld, err, ser}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(vld == 0 && err == 0 && ser == 0 && sym == 0, "R1 after release",
            int'({sym, vld, err, ser}), 0);

        // R2 R3 R4 R6: sweep every pulse width in back-to-back periods
        for (int w = 1; w <= PERIOD - 2; w++) send(w, PERIOD);
        for (int k = 3; k >= 0; k--) send(SLOT * (k + 1), PERIOD);

        // R5: second edge inside the window aborts and restarts
        begin
            int vc = 0;
            int ec = 0;
            int first = -1;
            int s = 0;
            line = 1'b1;
            for (int t = 1; t <= 40; t++) begin
                @(negedge clk);
                if (t == 3) line = 1'b0;
                if (t == 5) line = 1'b1;
                if (t == 15) line = 1'b0;
                if (vld) begin
                    if (first < 0) first = t;
                    vc++;
                    s = int'(sym);
                end
                if (err) ec++;
            end
            chk(ec == 1, "R5 abort error pulse", ec, 1);
            chk(vc == 1, "R5 no strobe for aborted period", vc, 1);
            chk(first == 5 + LAT, "R5 restart latency", first, 5 + LAT);
            chk(s == exp_sym(10), "R5 restarted symbol", s, exp_sym(10));
        end

        // R7: steady high then steady low
        begin
            int vc = 0;
            int s = 0;
            line = 1'b1;
            for (int t = 1; t <= 100; t++) begin
                @(negedge clk);
                if (vld) begin
                    vc++;
                    s = int'(sym);
                end
            end
            chk(vc == 1, "R7 held high one strobe", vc, 1);
            chk(s == 3, "R7 held high symbol", s, 3);
            line = 1'b0;
            vc = 0;
            for (int t = 1; t <= 80; t++) begin
                @(negedge clk);
                if (vld) vc++;
            end
            chk(vc == 0, "R7 held low no strobe", vc, 0);
            chk(ser == 0, "R6 serial idle", int'(ser), 0);
        end

        // R1: reset in mid-measurement clears everything
        begin
            int vc = 0;
            line = 1'b1;
            repeat (8) @(negedge clk);
            rst  = 1'b1;
            line = 1'b0;
            repeat (2) @(negedge clk);
            chk(vld == 0 && err == 0 && ser == 0 && sym == 0, "R1 mid reset",
                int'({sym, vld, err, ser}), 0);
            rst = 1'b0;
            for (int t = 1; t <= 40; t++) begin
                @(negedge clk);
                if (vld || err) vc++;
            end
            chk(vc == 0, "R1 measurement discarded", vc, 0);
            chk(sym == 0, "R1 symbol cleared", int'(sym), 0);
        end

        have_prev = 0;
        send(SLOT * 3, PERIOD);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule